// File: doc/BRIEF.md
# Fixed-Point Gain and Offset Stage

This block is one arithmetic step in a streaming audio datapath. Each cycle it can accept one 48-bit two's-complement sample, marked by a valid flag. It multiplies the sample by a 28-bit signed gain that has 23 fractional bits. It keeps the 48 bits of the product just above those 23 fractional bits and drops the fraction. A 48-bit signed level offset is then added. Both the product step and the add step clamp to the 48-bit signed limits instead of wrapping. The result leaves two cycles later with a matching valid flag.

The gain and the offset are loaded through a small write port that has an enable, a two-bit address and a 48-bit data word. A sample takes the coefficient values held in the bank on the cycle it enters. It carries its own copy of the offset through the pipeline. A write therefore never changes a sample that is already in flight, and it takes effect from the next sample accepted after the write.

Top module: `gain_offset_stage`

## Requirements
- R1: While reset is asserted and after it is released, out_valid is low and out_data is zero. The gain comes out of reset at 1.0 (0x0800000) and the offset at zero.
- R2: A sample accepted with in_valid high at a rising edge appears on out_data, with out_valid high, after the second rising edge that follows. out_valid is low in every other cycle.
- R3: The product is reduced by discarding its 23 least significant bits, which is an arithmetic floor. For example, 3 × 0.5 gives 1 and −3 × 0.5 gives −2.
- R4: A gain of 0x0800000 with a zero offset passes every 48-bit input through unchanged, including both extremes.
- R5: When the reduced product does not fit in 48 signed bits, it is clamped to 0x7FFF_FFFF_FFFF if it is positive and to 0x8000_0000_0000 if it is negative.
- R6: The offset is added as a 48-bit signed value to the reduced product.
- R7: If the offset sum is above 0x7FFF_FFFF_FFFF, the output is 0x7FFF_FFFF_FFFF.
- R8: If the offset sum is below −2^47, the output is 0x8000_0000_0000.
- R9: When wr_en is high, address 0 loads the gain from wr_data[27:0] and address 1 loads the offset from wr_data[47:0]. Writes to addresses 2 and 3 change nothing.
- R10: A coefficient write applies to samples accepted after it, but not to a sample accepted in the same cycle. A sample already inside the pipeline keeps the offset it entered with.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample qualifier |
| in_data | input | 48 | Signed input sample |
| wr_en | input | 1 | Coefficient write enable |
| wr_addr | input | 2 | Coefficient select: 0 gain, 1 offset |
| wr_data | input | 48 | Coefficient write value |
| out_valid | output | 1 | Output sample qualifier |
| out_data | output | 48 | Signed, saturated result |

## Verification
Some rules hold on every cycle, and the assertions check them there:
- the two-cycle valid alignment;
- the quiet output during reset;
- the sign of the reduced product for operands of equal and of opposite signs, which a wrapped overflow would break;
- the sign of the sum when the product and the offset share a sign;
- writes to the unused addresses leaving both coefficients untouched.

Other behaviour only the scenarios of the bench can show, because it depends on exact values and on timing:
- the floor rounding of the product;
- the exact clamp values;
- unity pass-through;
- the address map;
- a sample that must keep its old offset while a write lands behind it.

// File: rtl/gos_pkg.sv
package gos_pkg;
    localparam int COEF_ADDR_W = 2;
    localparam logic [COEF_ADDR_W-1:0] ADDR_GAIN   = 2'd0;
    localparam logic [COEF_ADDR_W-1:0] ADDR_OFFSET = 2'd1;
endpackage

// File: rtl/gos_coef_bank.sv
module gos_coef_bank
    import gos_pkg::*;
#(
    parameter int DATA_W    = 48,
    parameter int GAIN_W    = 28,
    parameter int GAIN_FRAC = 23
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [COEF_ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    output logic signed [GAIN_W-1:0] gain_q,
    output logic signed [DATA_W-1:0] offs_q
);
    localparam logic signed [GAIN_W-1:0] GAIN_ONE =
        {{(GAIN_W-GAIN_FRAC-1){1'b0}}, 1'b1, {GAIN_FRAC{1'b0}}};

    typedef struct packed {
        logic signed [GAIN_W-1:0] gain;
        logic signed [DATA_W-1:0] offs;
    } coef_t;

    coef_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (wr_en) begin
            case (wr_addr)
                ADDR_GAIN:   c_d.gain = wr_data[GAIN_W-1:0];
                ADDR_OFFSET: c_d.offs = wr_data;
                default:     c_d = c_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.gain <= GAIN_ONE;
            c_q.offs <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign gain_q = c_q.gain;
    assign offs_q = c_q.offs;
endmodule

// File: rtl/gos_mul_stage.sv
module gos_mul_stage #(
    parameter int DATA_W    = 48,
    parameter int GAIN_W    = 28,
    parameter int GAIN_FRAC = 23
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_data,
    input  logic signed [GAIN_W-1:0] gain,
    input  logic signed [DATA_W-1:0] offs,
    output logic                     s1_valid,
    output logic signed [DATA_W-1:0] s1_data,
    output logic signed [DATA_W-1:0] s1_offs
);
    localparam int PROD_W = DATA_W + GAIN_W;
    localparam int HI     = GAIN_FRAC + DATA_W - 1;
    localparam int TOP_W  = PROD_W - HI;
    localparam logic signed [DATA_W-1:0] D_MAX = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic signed [DATA_W-1:0] D_MIN = {1'b1, {(DATA_W-1){1'b0}}};

    typedef struct packed {
        logic                     v;
        logic signed [DATA_W-1:0] d;
        logic signed [DATA_W-1:0] o;
    } s1_t;

    s1_t s_d, s_q;
    logic signed [PROD_W-1:0] prod;
    logic        [TOP_W-1:0]  top;
    logic signed [DATA_W-1:0] reduced;

    always_comb begin
        prod = in_data * gain;
        top  = prod[PROD_W-1:HI];
        if (top == {TOP_W{1'b0}} || top == {TOP_W{1'b1}}) begin
            reduced = prod[HI:GAIN_FRAC];
        end else if (prod[PROD_W-1]) begin
            reduced = D_MIN;
        end else begin
            reduced = D_MAX;
        end
        s_d   = s_q;
        s_d.v = in_valid;
        if (in_valid) begin
            s_d.d = reduced;
            s_d.o = offs;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign s1_valid = s_q.v;
    assign s1_data  = s_q.d;
    assign s1_offs  = s_q.o;
endmodule

// File: rtl/gos_sat_add.sv
module gos_sat_add #(
    parameter int DATA_W = 48
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     s1_valid,
    input  logic signed [DATA_W-1:0] s1_data,
    input  logic signed [DATA_W-1:0] s1_offs,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_data
);
    localparam logic signed [DATA_W-1:0] D_MAX = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic signed [DATA_W-1:0] D_MIN = {1'b1, {(DATA_W-1){1'b0}}};

    typedef struct packed {
        logic                     v;
        logic signed [DATA_W-1:0] d;
    } out_t;

    out_t o_d, o_q;
    logic signed [DATA_W:0] sum;

    always_comb begin
        sum   = {s1_data[DATA_W-1], s1_data} + {s1_offs[DATA_W-1], s1_offs};
        o_d   = o_q;
        o_d.v = s1_valid;
        if (s1_valid) begin
            if (sum[DATA_W] != sum[DATA_W-1]) begin
                o_d.d = sum[DATA_W] ? D_MIN : D_MAX;
            end else begin
                o_d.d = sum[DATA_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign out_valid = o_q.v;
    assign out_data  = o_q.d;
endmodule

// File: rtl/gain_offset_stage.sv
module gain_offset_stage
    import gos_pkg::*;
#(
    parameter int DATA_W    = 48,
    parameter int GAIN_W    = 28,
    parameter int GAIN_FRAC = 23
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [DATA_W-1:0]      in_data,
    input  logic                   wr_en,
    input  logic [COEF_ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0]      wr_data,
    output logic                   out_valid,
    output logic [DATA_W-1:0]      out_data
);
    logic signed [GAIN_W-1:0] gain_q;
    logic signed [DATA_W-1:0] offs_q;
    logic                     s1_valid;
    logic signed [DATA_W-1:0] s1_data;
    logic signed [DATA_W-1:0] s1_offs;
    logic signed [DATA_W-1:0] res;

    gos_coef_bank #(.DATA_W(DATA_W), .GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .gain_q(gain_q), .offs_q(offs_q)
    );

    gos_mul_stage #(.DATA_W(DATA_W), .GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC)) u_mul (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data($signed(in_data)),
        .gain(gain_q), .offs(offs_q),
        .s1_valid(s1_valid), .s1_data(s1_data), .s1_offs(s1_offs)
    );

    gos_sat_add #(.DATA_W(DATA_W)) u_add (
        .clk(clk), .rst_n(rst_n), .s1_valid(s1_valid), .s1_data(s1_data),
        .s1_offs(s1_offs), .out_valid(out_valid), .out_data(res)
    );

    assign out_data = res;
endmodule

// File: rtl/gos_checker.sv
module gos_checker #(
    parameter int DATA_W = 48,
    parameter int GAIN_W = 28
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     in_valid,
    input logic [DATA_W-1:0]        in_data,
    input logic                     wr_en,
    input logic [1:0]               wr_addr,
    input logic                     out_valid,
    input logic [DATA_W-1:0]        out_data,
    input logic                     s1_valid,
    input logic signed [DATA_W-1:0] s1_data,
    input logic signed [DATA_W-1:0] s1_offs,
    input logic signed [GAIN_W-1:0] gain_q,
    input logic signed [DATA_W-1:0] offs_q
);
    logic [1:0] since_rst;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              since_rst <= 2'd0;
        else if (since_rst != 2) since_rst <= since_rst + 2'd1;
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_data == '0)); // R1

    AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        since_rst == 2'd2 |-> out_valid == $past(in_valid, 2)); // R2

    AST_PROD_SIGN_POS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_data != '0 && gain_q != '0 && in_data[DATA_W-1] == gain_q[GAIN_W-1])
        |=> (s1_valid && !s1_data[DATA_W-1])); // R5

    AST_PROD_SIGN_NEG: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_data != '0 && gain_q != '0 && in_data[DATA_W-1] != gain_q[GAIN_W-1])
        |=> (s1_valid && s1_data[DATA_W-1])); // R3

    AST_SUM_NO_WRAP_POS: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && !s1_data[DATA_W-1] && !s1_offs[DATA_W-1]) |=> !out_data[DATA_W-1]); // R7

    AST_SUM_NO_WRAP_NEG: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && s1_data[DATA_W-1] && s1_offs[DATA_W-1]) |=> out_data[DATA_W-1]); // R8

    AST_UNUSED_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr[1]) |=> ($stable(gain_q) && $stable(offs_q))); // R9
endmodule

bind gain_offset_stage gos_checker #(.DATA_W(DATA_W), .GAIN_W(GAIN_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .out_valid(out_valid), .out_data(out_data),
    .s1_valid(s1_valid), .s1_data(s1_data), .s1_offs(s1_offs),
    .gain_q(gain_q), .offs_q(offs_q)
);

// File: tb/gain_offset_stage_test.sv
module gain_offset_stage_test;
    localparam logic [47:0] PMAX = 48'h7FFF_FFFF_FFFF;
    localparam logic [47:0] NMIN = 48'h8000_0000_0000;
    localparam logic signed [127:0] BIG_MAX = 128'sh7FFF_FFFF_FFFF;
    localparam logic signed [127:0] BIG_MIN = -128'sh8000_0000_0000;

    logic clk = 0, rst_n = 0, in_valid = 0, wr_en = 0;
    logic [47:0] in_data = '0, wr_data = '0;
    logic [1:0]  wr_addr = '0;
    logic        out_valid;
    logic [47:0] out_data;

    int checks = 0, failures = 0, cyc = 0;
    logic [27:0] m_gain = 28'h0800000;
    logic [47:0] m_offs = '0;

    typedef struct { logic [47:0] exp; int stamp; string req; } item_t;
    item_t q[$];

    gain_offset_stage uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .out_valid(out_valid), .out_data(out_data)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input logic ok, input string req, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [47:0] model(input logic [47:0] x, input logic [27:0] g, input logic [47:0] o);
        logic signed [127:0] p;
        p = ($signed({{80{x[47]}}, x}) * $signed({{100{g[27]}}, g})) >>> 23;
        if (p > BIG_MAX) p = BIG_MAX;
        if (p < BIG_MIN) p = BIG_MIN;
        p = p + $signed({{80{o[47]}}, o});
        if (p > BIG_MAX) p = BIG_MAX;
        if (p < BIG_MIN) p = BIG_MIN;
        return p[47:0];
    endfunction

    // drive one sample; an optional write lands on the same edge
    task automatic send(input logic [47:0] x, input string req,
                        input logic we = 0, input logic [1:0] wa = 0, input logic [47:0] wd = 0);
        item_t it;
        @(negedge clk);
        in_valid = 1; in_data = x;
        wr_en = we; wr_addr = wa; wr_data = wd;
        it.exp = model(x, m_gain, m_offs); it.stamp = cyc; it.req = req;
        q.push_back(it);
        if (we && wa == 2'd0) m_gain = wd[27:0];
        if (we && wa == 2'd1) m_offs = wd;
    endtask

    task automatic wr(input logic [1:0] a, input logic [47:0] d);
        @(negedge clk);
        in_valid = 0; wr_en = 1; wr_addr = a; wr_data = d;
        if (a == 2'd0) m_gain = d[27:0];
        if (a == 2'd1) m_offs = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 0; wr_en = 0;
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (q.size() == 0) begin
                chk(0, "R2 unexpected out_valid", out_data, '0);
            end else begin
                item_t it;
                it = q.pop_front();
                chk(out_data == it.exp, it.req, out_data, it.exp);
                chk(cyc == it.stamp + 2, "R2 latency", 48'(cyc - it.stamp), 48'd2);
            end
        end
    end

    initial begin
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!out_valid && out_data == '0, "R1 reset outputs", out_data, '0);
        rst_n = 1;
        @(negedge clk);
        chk(!out_valid && out_data == '0, "R1 after release", out_data, '0);

        // R4 unity defaults
        send(48'd0, "R4 unity zero");
        send(48'd1, "R4 unity one");
        send('1, "R4 unity minus one");
        send(PMAX, "R4 unity max");
        send(NMIN, "R4 unity min");
        send(48'h0123_4567_89AB, "R4 unity pattern");
        idle(3);

        // R3 truncation with gain 0.5 and -1.5
        wr(2'd0, 48'h0400000);
        send(48'd3, "R3 3*0.5");
        send(-48'sd3, "R3 -3*0.5");
        wr(2'd0, 48'h0F400000);
        send(48'd1000, "R3 1000*-1.5");
        send(48'd1, "R3 1*-1.5");
        idle(3);

        // R5 product clamp
        wr(2'd0, 48'h7FFFFFF);
        send(PMAX, "R5 pos clamp");
        send(NMIN, "R5 neg clamp");
        wr(2'd0, 48'h8000000);
        send(NMIN, "R5 min*min clamp");
        send(48'd5, "R5 no clamp");
        idle(3);

        // R6..R8 offset and saturation
        wr(2'd0, 48'h0800000);
        wr(2'd1, 48'd1000);
        send(48'd5, "R6 offset add");
        send(-48'sd2000, "R6 offset negative result");
        wr(2'd1, PMAX);
        send(48'd1, "R7 positive saturation");
        send(PMAX, "R7 max plus max");
        wr(2'd1, NMIN);
        send('1, "R8 negative saturation");
        send(NMIN, "R8 min plus min");
        idle(3);

        // R9 unused addresses ignored, used ones decoded
        wr(2'd1, 48'd7);
        wr(2'd2, 48'hDEAD_BEEF_0000);
        wr(2'd3, 48'h1234_0000_0000);
        send(48'd100, "R9 ignore addr 2/3");
        wr(2'd0, 48'h1000000);
        send(48'd100, "R9 gain addr 0");
        idle(3);

        // R10 write timing relative to samples
        wr(2'd0, 48'h0800000);
        wr(2'd1, 48'd0);
        send(48'd50, "R10 same-cycle write not applied", 1'b1, 2'd1, 48'd9);
        send(48'd60, "R10 in-flight keeps offset", 1'b1, 2'd1, 48'd500);
        send(48'd70, "R10 next sample uses new offset");
        idle(4);

        chk(q.size() == 0, "R2 all results delivered", 48'(q.size()), '0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule